// File: doc/BRIEF.md
# Auxiliary Converter Serial Control and Status Port

This block is the serial slave that controls an auxiliary analog-to-digital converter and reads its results. A host drives a chip select (active low), a serial clock and a data input. Each complete 16-bit frame carries a 4-bit address and 12 data bits. A frame sent to the control address updates four things: the averaging code, the clock-divider code and the data-output mode, and it can also start a conversion. A frame sent to any other address is dropped. A host that only wants to read can therefore hold the data line high for a whole frame without changing any setting.

The single serial output has two roles, and it is driven only while chip select is low:

- **Status line.** After a start, it is high while the conversion runs. It goes low once the sequencer has delivered the result.
- **Data line.** If data-output mode is set, the next chip-select frame after the result arrives shifts the 10-bit result out, MSB first. The line changes on falling serial-clock edges.

The serial pins are sampled in the system clock domain through two-flop synchronizers. The system clock must therefore run at least four times faster than the serial clock. On the converter side, the block gives the sequencer a one-cycle start pulse and the two codes. In return it takes a done pulse together with the result.

Top module: `auxcfg_port`

## Requirements
- R1: After reset the averaging code, divider code and output-mode bit are 0, the output enable is 0, and no start pulse is produced.
- R2: A 16-bit frame is sent MSB first, with bits sampled on rising serial-clock edges. Frame bits 15:12 are the address and bits 11:0 are data. When the address equals CTRL_ADDR (default 3), the data loads the control fields as follows:
  - averaging code from data bits 6:4;
  - divider code from data bits 9:7;
  - output-mode bit from data bit 10.
- R3: A frame whose address differs from CTRL_ADDR changes no output and produces no start pulse. This includes address 1111, so a frame of all ones writes nothing.
- R4: A frame with fewer than 16 bits is discarded when chip select rises. Serial-clock pulses after the 16th bit of a frame are ignored.
- R5: Data bit 0 of a control frame is the start bit. When it is 1, conv_start_o pulses for exactly one cycle. The start bit is not stored, so a later control frame with bit 0 at 0 produces no pulse.
- R6: dout_oe_o is 0 whenever chip select is high. It is also 0 while chip select is low if no conversion has been started since reset or since the last readout frame.
- R7: From a start until conv_done_i, a chip-select-low period shows dout_oe_o = 1 and dout_o = 1. After conv_done_i it shows dout_oe_o = 1 and dout_o = 0.
- R8: With output mode 1 and a result held, the next chip-select falling edge starts a readout. The 10 result bits are presented MSB first, each new bit after a falling serial-clock edge, and the line is low after the 10th bit. When chip select rises, the block returns to the idle, undriven state.
- R9: With output mode 0, the result never appears on dout_o: every chip-select-low period after the done pulse shows a driven low level.
- R10: Frames received on the data input take effect while a readout is shifting out, and the readout data is unaffected by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| din_i | input | 1 | Serial instruction input |
| dout_o | output | 1 | Serial status/data output value |
| dout_oe_o | output | 1 | Output enable for dout_o (0 = high impedance) |
| conv_start_o | output | 1 | One-cycle conversion start pulse to the sequencer |
| avg_code_o | output | 3 | Averaging code for the sequencer |
| div_code_o | output | 3 | Conversion clock divider code |
| out_mode_o | output | 1 | Data-output mode enable |
| conv_done_i | input | 1 | Sequencer pulse: result is valid |
| conv_result_i | input | RES_W (10) | Conversion result, valid with conv_done_i |

## Verification
The bench builds the block with its default parameters: control address 3, two synchronizer stages and a 10-bit result. With 3-bit codes, all 64 pairs of averaging and divider codes can be written and read back, each pair with the output-mode bit set to a value computed from the pair. Every one of the 16 addresses is tried with all-ones data, which covers the 1111 no-op. A 10-bit result is small enough to check bit by bit over several patterns, including all ones, all zeros and single set bits at both ends.

// File: rtl/auxcfg_pkg.sv
package auxcfg_pkg;

    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 12;
    localparam int FRAME_W  = ADDR_W + DATA_W;
    localparam int CODE_W   = 3;

    // Field positions inside the 12 data bits of the control frame
    localparam int START_BIT = 0;
    localparam int AVG_LSB   = 4;
    localparam int DIV_LSB   = 7;
    localparam int MODE_BIT  = 10;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef struct packed {
        logic              out_mode;
        logic [CODE_W-1:0] div;
        logic [CODE_W-1:0] avg;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_READY = 2'd2,
        ST_SHIFT = 2'd3
    } dstate_e;

    function automatic ctrl_t decode_ctrl(input logic [DATA_W-1:0] d);
        ctrl_t c;
        c.avg      = d[AVG_LSB +: CODE_W];
        c.div      = d[DIV_LSB +: CODE_W];
        c.out_mode = d[MODE_BIT];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] used_data_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        m[START_BIT]           = 1'b1;
        m[AVG_LSB +: CODE_W]   = '1;
        m[DIV_LSB +: CODE_W]   = '1;
        m[MODE_BIT]            = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/auxcfg_sync.sv
module auxcfg_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            prev_q <= RST_VAL;
        end else begin
            stg[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            prev_q <= stg[STAGES-1];
        end
    end

    assign level_o = stg[STAGES-1];

    for (genvar b = 0; b < W; b++) begin : g_edge
        assign rise_o[b] =  level_o[b] & ~prev_q[b];
        assign fall_o[b] = ~level_o[b] &  prev_q[b];
    end

endmodule

// File: rtl/auxcfg_rx.sv
module auxcfg_rx
    import auxcfg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cs_lvl_i,
    input  logic   sclk_rise_i,
    input  logic   din_lvl_i,
    output logic   frame_valid_o,
    output frame_t frame_o
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt           <= '0;
            sh            <= '0;
            frame_valid_o <= 1'b0;
        end else begin
            frame_valid_o <= 1'b0;
            if (cs_lvl_i) begin
                cnt <= '0;
            end else if (sclk_rise_i && cnt != FULL) begin
                sh  <= {sh[FRAME_W-2:0], din_lvl_i};
                cnt <= cnt + 1'b1;
                if (cnt == LAST) frame_valid_o <= 1'b1;
            end
        end
    end

    assign frame_o = frame_t'(sh);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL);                                                   // R4
    AST_COMMIT_FULL: assert property (@(posedge clk) disable iff (rst)
        frame_valid_o |-> (cnt == FULL));                               // R2
    AST_NO_COMMIT_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
        $past(cs_lvl_i) |-> !frame_valid_o);                            // R4

endmodule

// File: rtl/auxcfg_ctrl.sv
module auxcfg_ctrl
    import auxcfg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   frame_valid_i,
    input  frame_t frame_i,
    output ctrl_t  cfg_o,
    output logic   start_o
);
    localparam logic [DATA_W-1:0] USED = used_data_mask();

    logic hit;
    logic unused_data;

    assign hit         = frame_valid_i && (frame_i.addr == CTRL_ADDR);
    assign unused_data = ^(frame_i.data & ~USED);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o   <= '0;
            start_o <= 1'b0;
        end else begin
            start_o <= 1'b0;
            if (hit) begin
                cfg_o   <= decode_ctrl(frame_i.data);
                start_o <= frame_i.data[START_BIT];
            end
        end
    end

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);                                          // R5
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(cfg_o));                                       // R3
    AST_START_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        start_o |-> $past(hit));                                        // R5

endmodule

// File: rtl/auxcfg_dout.sv
module auxcfg_dout
    import auxcfg_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_lvl_i,
    input  logic             cs_rise_i,
    input  logic             cs_fall_i,
    input  logic             sclk_fall_i,
    input  logic             start_i,
    input  logic             out_mode_i,
    input  logic             done_i,
    input  logic [RES_W-1:0] result_i,
    output logic             dout_o,
    output logic             dout_oe_o
);
    dstate_e          state;
    logic [RES_W-1:0] res_q;
    logic [RES_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            res_q <= '0;
            sh    <= '0;
        end else if (start_i) begin
            state <= ST_BUSY;
        end else begin
            unique case (state)
                ST_BUSY: begin
                    if (done_i) begin
                        res_q <= result_i;
                        state <= ST_READY;
                    end
                end
                ST_READY: begin
                    if (cs_fall_i && out_mode_i) begin
                        sh    <= res_q;
                        state <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (cs_rise_i)        state <= ST_IDLE;
                    else if (sclk_fall_i) sh    <= {sh[RES_W-2:0], 1'b0};
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        dout_oe_o = !cs_lvl_i && (state != ST_IDLE);
        unique case (state)
            ST_BUSY:  dout_o = 1'b1;
            ST_SHIFT: dout_o = sh[RES_W-1];
            default:  dout_o = 1'b0;
        endcase
    end

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (state == ST_BUSY));                                // R7
    AST_READY_LATCH: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BUSY && done_i && !start_i)
            |=> (state == ST_READY && res_q == $past(result_i)));       // R7
    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ST_SHIFT) |-> $past(out_mode_i && cs_fall_i));   // R8
    AST_NO_DATA_MODE0: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READY && !out_mode_i) |=> (state != ST_SHIFT));    // R9
    AST_CS_RISE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT && cs_rise_i && !start_i) |=> (state == ST_IDLE)); // R6

endmodule

// File: rtl/auxcfg_port.sv
module auxcfg_port
    import auxcfg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 4'h3,
    parameter int                SYNC_STAGES = 2,
    parameter int                RES_W       = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n_i,
    input  logic             sclk_i,
    input  logic             din_i,
    output logic             dout_o,
    output logic             dout_oe_o,
    output logic             conv_start_o,
    output logic [CODE_W-1:0] avg_code_o,
    output logic [CODE_W-1:0] div_code_o,
    output logic             out_mode_o,
    input  logic             conv_done_i,
    input  logic [RES_W-1:0] conv_result_i
);
    localparam int PIN_DIN  = 0;
    localparam int PIN_SCLK = 1;
    localparam int PIN_CS   = 2;
    localparam int PINS     = 3;

    logic [PINS-1:0] pins;
    logic [PINS-1:0] lvl;
    logic [PINS-1:0] rise;
    logic [PINS-1:0] fall;
    logic            unused_edges;

    frame_t frame;
    logic   frame_valid;
    ctrl_t  cfg;

    assign pins[PIN_DIN]  = din_i;
    assign pins[PIN_SCLK] = sclk_i;
    assign pins[PIN_CS]   = cs_n_i;
    assign unused_edges   = ^{rise[PIN_DIN], fall[PIN_DIN]};

    auxcfg_sync #(
        .W       (PINS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b101)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pins),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    auxcfg_rx u_rx (
        .clk           (clk),
        .rst           (rst),
        .cs_lvl_i      (lvl[PIN_CS]),
        .sclk_rise_i   (rise[PIN_SCLK]),
        .din_lvl_i     (lvl[PIN_DIN]),
        .frame_valid_o (frame_valid),
        .frame_o       (frame)
    );

    auxcfg_ctrl #(
        .CTRL_ADDR (CTRL_ADDR)
    ) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .frame_valid_i (frame_valid),
        .frame_i       (frame),
        .cfg_o         (cfg),
        .start_o       (conv_start_o)
    );

    auxcfg_dout #(
        .RES_W (RES_W)
    ) u_dout (
        .clk         (clk),
        .rst         (rst),
        .cs_lvl_i    (lvl[PIN_CS]),
        .cs_rise_i   (rise[PIN_CS]),
        .cs_fall_i   (fall[PIN_CS]),
        .sclk_fall_i (fall[PIN_SCLK]),
        .start_i     (conv_start_o),
        .out_mode_i  (cfg.out_mode),
        .done_i      (conv_done_i),
        .result_i    (conv_result_i),
        .dout_o      (dout_o),
        .dout_oe_o   (dout_oe_o)
    );

    assign avg_code_o = cfg.avg;
    assign div_code_o = cfg.div;
    assign out_mode_o = cfg.out_mode;

    AST_OE_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
        lvl[PIN_CS] |-> !dout_oe_o);                                    // R6

endmodule

// File: tb/tb_auxcfg_port.sv
module tb_auxcfg_port;

    localparam logic [3:0] CA = 4'h3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, sclk = 1'b0, din = 1'b1, done = 1'b0;
    logic [9:0] res = '0;

    logic       dout, oe, st, mode;
    logic [2:0] avg, div;

    int  checks = 0, fails = 0, starts = 0;
    bit  ended = 1'b0;

    always #5 clk = ~clk;

    auxcfg_port dut (
        .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .din_i(din),
        .dout_o(dout), .dout_oe_o(oe), .conv_start_o(st),
        .avg_code_o(avg), .div_code_o(div), .out_mode_o(mode),
        .conv_done_i(done), .conv_result_i(res)
    );

    always @(negedge clk) if (!rst && st) starts++;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] mk(input logic [3:0] a, input logic [2:0] av,
                                       input logic [2:0] dv, input logic m, input logic s);
        return {a, 1'b0, m, dv, av, 3'b000, s};
    endfunction

    function automatic int cfgv(input logic [2:0] av, input logic [2:0] dv, input logic m);
        return int'({av, dv, m});
    endfunction

    task automatic frame(input logic [15:0] tx, input int nbits,
                         output logic [15:0] rxd, output logic [15:0] rxe);
        rxd = '0; rxe = '0;
        cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            din = (i < 16) ? tx[15-i] : 1'b0;
            tick(4);
            sclk = 1'b1;
            tick(4);
            if (i < 16) begin
                rxd[15-i] = dout;
                rxe[15-i] = oe;
            end
            sclk = 1'b0;
        end
        din = 1'b1;
        tick(4);
        cs_n = 1'b1;
        tick(10);
    endtask

    task automatic poll(output logic d, output logic e);
        cs_n = 1'b0;
        tick(8);
        d = dout; e = oe;
        cs_n = 1'b1;
        tick(8);
    endtask

    task automatic finish_conv(input logic [9:0] r);
        tick(5);
        res = r; done = 1'b1;
        tick(1);
        done = 1'b0;
        tick(3);
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] rd, re;
        logic        d, e;
        int          s0;
        logic [9:0]  vals [6];
        vals = '{10'h2A5, 10'h3FF, 10'h000, 10'h155, 10'h001, 10'h200};

        tick(4); rst = 1'b0; tick(4);

        // R1: reset state
        chk("R1", "oe", int'(oe), 0);
        chk("R1", "cfg", cfgv(avg, div, mode), 0);
        chk("R1", "start pulses", starts, 0);

        // R6: idle, chip select low, not driven
        poll(d, e);
        chk("R6", "oe idle cs low", int'(e), 0);

        // R2: sweep all code pairs
        for (int a = 0; a < 8; a++) begin
            for (int v = 0; v < 8; v++) begin
                logic m;
                m = logic'((a ^ v) & 1);
                frame(mk(CA, 3'(a), 3'(v), m, 1'b0), 16, rd, re);
                chk("R2", "cfg sweep", cfgv(avg, div, mode), cfgv(3'(a), 3'(v), m));
            end
        end
        frame(mk(CA, 3'd5, 3'd2, 1'b1, 1'b0), 16, rd, re);
        chk("R2", "cfg set", cfgv(avg, div, mode), cfgv(3'd5, 3'd2, 1'b1));

        // R3: every other address with all-ones data is a no-op
        s0 = starts;
        for (int a = 0; a < 16; a++) begin
            if (4'(a) != CA) begin
                frame({4'(a), 12'hFFF}, 16, rd, re);
                chk("R3", "cfg unchanged", cfgv(avg, div, mode), cfgv(3'd5, 3'd2, 1'b1));
                chk("R3", "no start", starts, s0);
                chk("R6", "oe never on", int'(re), 0);
            end
        end

        // R4: short frame discarded, extra bits ignored
        frame(mk(CA, 3'd1, 3'd1, 1'b0, 1'b1), 15, rd, re);
        chk("R4", "short frame cfg", cfgv(avg, div, mode), cfgv(3'd5, 3'd2, 1'b1));
        chk("R4", "short frame start", starts, s0);
        frame(mk(CA, 3'd3, 3'd6, 1'b1, 1'b0), 17, rd, re);
        chk("R4", "long frame cfg", cfgv(avg, div, mode), cfgv(3'd3, 3'd6, 1'b1));

        // R5: start pulse once, not sticky
        frame(mk(CA, 3'd3, 3'd6, 1'b1, 1'b1), 16, rd, re);
        chk("R5", "one start", starts, s0 + 1);
        chk("R5", "cfg with start", cfgv(avg, div, mode), cfgv(3'd3, 3'd6, 1'b1));
        frame(mk(CA, 3'd3, 3'd6, 1'b1, 1'b0), 16, rd, re);
        chk("R5", "start not sticky", starts, s0 + 1);

        // R6: cs high while busy -> undriven
        tick(3);
        chk("R6", "oe cs high busy", int'(oe), 0);

        // R8: readouts over several result patterns
        for (int k = 0; k < 6; k++) begin
            if (k != 0) frame(mk(CA, 3'd3, 3'd6, 1'b1, 1'b1), 16, rd, re);
            poll(d, e);
            chk("R7", "busy oe", int'(e), 1);
            chk("R7", "busy level", int'(d), 1);
            finish_conv(vals[k]);
            frame(16'hFFFF, 16, rd, re);
            chk("R8", "result bits", int'(rd[15:6]), int'(vals[k]));
            chk("R8", "trailing low", int'(rd[5:0]), 0);
            chk("R8", "driven in frame", int'(re), 16'hFFFF);
            chk("R3", "ones frame no write", cfgv(avg, div, mode), cfgv(3'd3, 3'd6, 1'b1));
            poll(d, e);
            chk("R8", "idle after readout", int'(e), 0);
        end

        // R10: configuration frame during readout
        frame(mk(CA, 3'd3, 3'd6, 1'b1, 1'b1), 16, rd, re);
        finish_conv(10'h1B3);
        frame(mk(CA, 3'd6, 3'd1, 1'b1, 1'b0), 16, rd, re);
        chk("R10", "readout during write", int'(rd[15:6]), 10'h1B3);
        chk("R10", "write during readout", cfgv(avg, div, mode), cfgv(3'd6, 3'd1, 1'b1));

        // R9: output mode 0 never shows data
        frame(mk(CA, 3'd6, 3'd1, 1'b0, 1'b1), 16, rd, re);
        poll(d, e);
        chk("R7", "mode0 busy level", int'(d), 1);
        finish_conv(10'h3FF);
        poll(d, e);
        chk("R7", "ready oe", int'(e), 1);
        chk("R7", "ready level", int'(d), 0);
        frame(16'hFFFF, 16, rd, re);
        chk("R9", "no data mode0", int'(rd), 0);
        chk("R9", "driven low mode0", int'(re), 16'hFFFF);
        poll(d, e);
        chk("R9", "still low", int'({e, d}), 2);

        summary();
        $finish;
    end

endmodule